// File: doc/BRIEF.md
# One-Time-Programmable Word Memory With Mode Decoding

This block is a synthesizable behavioural model of a 16-bit-wide one-time-programmable read-only memory. Two active-low controls (chip enable and output enable) and two boolean qualifiers are decoded into the operating mode. One qualifier says that the programming supply is at its high voltage. The other says that address bit 9 is at its high voltage. The analog levels of a real part are reduced to these flags, and its access and float delays become cycle counts set by parameters.

With the supply at its normal level, the block reads, disables its outputs, stands by, or returns a fixed identification word. With the supply high, it programs, verifies or inhibits. Programming can only clear bits that are still set, so the erased state is all ones. The output bus is tri-stated, and a separate flag reports when the bus is driven. The full-size part has an 18-bit address (262,144 words). The default here is 10 bits, so that elaboration stays small. Address bit 9 must exist because the identification decode uses it.

Top module: `otp_eprom`

## Requirements
- R1: After reset every word reads 0xFFFF and the outputs are not driven (`dq_en_o` = 0).
- R2: With `ce_ni`=0, `oe_ni`=0 and the supply normal, the addressed word is driven. An address or qualifier change, or a falling `ce_ni`, sampled at clock edge k makes the word valid after edge k+ACC_CYC and not before.
- R3: A falling `oe_ni` sampled at edge k, with access already complete, drives the word after edge k+OE_CYC and not earlier.
- R4: `oe_ni`=1 leaves the outputs undriven whatever `ce_ni` is. `ce_ni`=1 with the supply normal is standby, also undriven.
- R5: When the drive condition ends at edge k, `dq_en_o` falls after edge k+DF_CYC. Until then the bus holds its last word.
- R6: While the bus is driven and an access is pending, the bus keeps its previous word until the new one becomes valid.
- R7: With the supply high, `ce_ni`=0 and `oe_ni`=1, each clock edge replaces the addressed word with the word ANDed with `din_i`. The bus is not driven in this mode.
- R8: With the supply high, `ce_ni`=1 and `oe_ni`=0, the stored word is driven (verify).
- R9: With the supply high and both controls high, the bus is undriven and no word changes.
- R10: `ce_ni`=0 with `oe_ni`=1 and the supply normal writes nothing.
- R11: With `ce_ni`=`oe_ni`=0, the supply normal and `a9_hv_i`=1, and every address bit other than 0 and 9 at zero, the bus returns 0x001E when bit 0 is 0 and 0x00F4 when bit 0 is 1. The logic level of bit 9 is ignored. If any other bit is set, the array word is read instead.
- R12: Programming never returns a cleared bit to one: 0x1234 followed by 0xFF00 leaves 0x1200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| vpp_hv_i | input | 1 | Programming supply at high voltage |
| a9_hv_i | input | 1 | Address bit 9 at high voltage |
| addr_i | input | ADDR_W | Word address |
| din_i | input | 16 | Word to program |
| dq_o | output | 16 | Tri-stated data bus |
| dq_en_o | output | 1 | Data bus is driven |

## Verification
The properties assume that each control or address change is sampled cleanly at one clock edge and held at least until the next edge. They also assume that the programming-supply flag never changes together with a direct jump between program mode and verify mode. The stimulus changes inputs only at the falling clock edge. It always passes through the inhibit state when it moves between programming and verifying. It also waits longer than the largest access delay between steps, so every pending access or float has finished before the next change.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned WORD_W = 16;

  typedef enum logic [2:0] {
    M_STANDBY,
    M_OUT_OFF,
    M_READ,
    M_IDENT,
    M_PROG,
    M_VERIFY,
    M_INHIBIT
  } otp_mode_e;

  localparam logic [WORD_W-1:0] MFR_WORD = 16'h001E;
  localparam logic [WORD_W-1:0] DEV_WORD = 16'h00F4;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hv_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              drive_req_o,
  output logic              wr_en_o,
  output logic              id_sel_o
);
  // Bits 0 and 9 take part in the identification decode; all others must be zero.
  localparam logic [ADDR_W-1:0] ID_MASK = ~(ADDR_W'(1) | (ADDR_W'(1) << 9));

  otp_mode_e mode;
  logic      id_addr_ok;

  assign id_addr_ok = (addr_i & ID_MASK) == '0;

  always_comb begin
    if (vpp_hv_i) begin
      unique case ({ce_ni, oe_ni})
        2'b01:   mode = M_PROG;
        2'b10:   mode = M_VERIFY;
        2'b11:   mode = M_INHIBIT;
        default: mode = M_READ;
      endcase
    end else if (ce_ni) begin
      mode = M_STANDBY;
    end else if (oe_ni) begin
      mode = M_OUT_OFF;
    end else if (a9_hv_i && id_addr_ok) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end

  assign drive_req_o = (mode == M_READ) || (mode == M_IDENT) || (mode == M_VERIFY);
  assign wr_en_o     = (mode == M_PROG);
  assign id_sel_o    = (mode == M_IDENT);
endmodule

// File: rtl/otp_array.sv
module otp_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] din_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  // Erased cells are ones; a write can only clear bits.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= mem_q[addr_i] & din_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/otp_out_timer.sv
module otp_out_timer #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned KEY_W   = 12,
  parameter int unsigned ACC_CYC = 5,
  parameter int unsigned OE_CYC  = 2,
  parameter int unsigned DF_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              drive_req_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o,
  output logic              en_o
);
  localparam int unsigned ACC_W = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam int unsigned OE_W  = (OE_CYC > 1) ? $clog2(OE_CYC) : 1;
  localparam int unsigned DF_W  = (DF_CYC > 1) ? $clog2(DF_CYC) : 1;
  localparam logic [ACC_W-1:0] ACC_LD = ACC_W'(ACC_CYC - 1);
  localparam logic [OE_W-1:0]  OE_LD  = OE_W'(OE_CYC - 1);
  localparam logic [DF_W-1:0]  DF_LD  = DF_W'(DF_CYC - 1);

  logic [KEY_W-1:0]  key_q;
  logic              ce_q, oe_q;
  logic [ACC_W-1:0]  acc_cnt;
  logic [OE_W-1:0]   oe_cnt;
  logic [DF_W-1:0]   df_cnt;
  logic              flt_pend;
  logic [WORD_W-1:0] data_q;
  logic              en_q;
  logic              acc_evt, oe_evt, ready;

  assign acc_evt = (key_i != key_q) || (ce_q && !ce_ni);
  assign oe_evt  = oe_q && !oe_ni;
  assign ready   = !acc_evt && !oe_evt && (acc_cnt == '0) && (oe_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q    <= '0;
      ce_q     <= 1'b1;
      oe_q     <= 1'b1;
      acc_cnt  <= '0;
      oe_cnt   <= '0;
      df_cnt   <= '0;
      flt_pend <= 1'b0;
      data_q   <= '0;
      en_q     <= 1'b0;
    end else begin
      key_q <= key_i;
      ce_q  <= ce_ni;
      oe_q  <= oe_ni;

      if (acc_evt)             acc_cnt <= ACC_LD;
      else if (acc_cnt != '0)  acc_cnt <= acc_cnt - ACC_W'(1);

      if (oe_evt)              oe_cnt <= OE_LD;
      else if (oe_cnt != '0)   oe_cnt <= oe_cnt - OE_W'(1);

      if (drive_req_i) begin
        flt_pend <= 1'b0;
        if (ready) begin
          data_q <= word_i;
          en_q   <= 1'b1;
        end
      end else if (en_q) begin
        // Float countdown starts at the first edge without a drive request.
        if (!flt_pend) begin
          flt_pend <= 1'b1;
          df_cnt   <= DF_LD;
        end else if (df_cnt != '0) begin
          df_cnt <= df_cnt - DF_W'(1);
        end else begin
          en_q     <= 1'b0;
          flt_pend <= 1'b0;
        end
      end
    end
  end

  assign data_o = data_q;
  assign en_o   = en_q;
endmodule

// File: rtl/otp_eprom.sv
module otp_eprom
  import otp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned ACC_CYC = 5,
  parameter int unsigned OE_CYC  = 2,
  parameter int unsigned DF_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              vpp_hv_i,
  input  logic              a9_hv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       din_i,
  output logic [15:0]       dq_o,
  output logic              dq_en_o
);
  localparam int unsigned KEY_W = ADDR_W + 2;

  logic              drive_req, wr_en, id_sel;
  logic [WORD_W-1:0] rdata, word_sel, dq_data;
  logic [KEY_W-1:0]  key;

  otp_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .vpp_hv_i    (vpp_hv_i),
    .a9_hv_i     (a9_hv_i),
    .addr_i      (addr_i),
    .drive_req_o (drive_req),
    .wr_en_o     (wr_en),
    .id_sel_o    (id_sel)
  );

  otp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .rdata_o (rdata)
  );

  assign word_sel = id_sel ? (addr_i[0] ? DEV_WORD : MFR_WORD) : rdata;
  assign key      = {vpp_hv_i, a9_hv_i, addr_i};

  otp_out_timer #(
    .WORD_W (WORD_W),
    .KEY_W  (KEY_W),
    .ACC_CYC(ACC_CYC),
    .OE_CYC (OE_CYC),
    .DF_CYC (DF_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .oe_ni       (oe_ni),
    .key_i       (key),
    .drive_req_i (drive_req),
    .word_i      (word_sel),
    .data_o      (dq_data),
    .en_o        (dq_en_o)
  );

  assign dq_o = dq_en_o ? dq_data : 'z;
endmodule

// File: rtl/otp_eprom_checks.sv
module otp_eprom_checks #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       dq_o,
  input logic              dq_en_o,
  input logic              drive_req_i,
  input logic              wr_en_i
);
  p_drive_needs_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_en_o) |-> $past(drive_req_i));

  p_no_early_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(oe_ni) || $fell(ce_ni)) |=> !$rose(dq_en_o));

  p_oe_gates_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_en_o) |-> $past(!oe_ni));

  p_float_after_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dq_en_o) |-> $past(!drive_req_i));

  p_hold_on_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_en_o && (addr_i != $past(addr_i))) |=> (!dq_en_o || $stable(dq_o)));

  p_no_drive_program_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !$rose(dq_en_o));
endmodule

bind otp_eprom otp_eprom_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_ni       (ce_ni),
  .oe_ni       (oe_ni),
  .addr_i      (addr_i),
  .dq_o        (dq_o),
  .dq_en_o     (dq_en_o),
  .drive_req_i (drive_req),
  .wr_en_i     (wr_en)
);

// File: tb/tb_otp_eprom.sv
module tb_otp_eprom;
  localparam int ADDR_W = 10;
  localparam int ACC    = 5;
  localparam int OEC    = 2;
  localparam int DF     = 2;

  typedef struct {
    int          due;
    bit          en;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce, oe, vpp, a9;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       din;
  wire  [15:0]       dq;
  wire               dq_en;

  int   cyc = 0;
  int   t = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  otp_eprom #(.ADDR_W(ADDR_W), .ACC_CYC(ACC), .OE_CYC(OEC), .DF_CYC(DF)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ce_ni    (ce),
    .oe_ni    (oe),
    .vpp_hv_i (vpp),
    .a9_hv_i  (a9),
    .addr_i   (addr),
    .din_i    (din),
    .dq_o     (dq),
    .dq_en_o  (dq_en)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int due, bit en, logic [15:0] val, string req);
    exp_t e;
    e.due = due; e.en = en; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic apply(bit c, bit o, bit v, bit h, logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk);
    ce = c; oe = o; vpp = v; a9 = h; addr = a; din = d;
    t = cyc;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations at their due cycle.
  always @(negedge clk) begin
    while (sb.size() != 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (dq_en !== e.en || (e.en && dq !== e.val)) begin
        errors++;
        $display("FAIL %s: en=%0b dq=%h expected en=%0b dq=%h (cycle %0d)",
                 e.req, dq_en, dq, e.en, e.val, cyc);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    ce = 1; oe = 1; vpp = 0; a9 = 0; addr = '0; din = '0; rst_n = 0;
    gap(3);
    rst_n = 1;
    @(negedge clk); t = cyc;
    expect_at(t, 0, 16'h0, "R1 reset undriven");
    gap(2);

    // Read of an erased word
    apply(0, 0, 0, 0, 5, 0);
    expect_at(t + ACC, 0, 16'h0, "R2 not valid before access delay");
    expect_at(t + 1 + ACC, 1, 16'hFFFF, "R1 erased word reads ones");
    gap(ACC + 3);

    // Program 0x1234 at word 5
    apply(0, 1, 1, 0, 5, 16'h1234);
    expect_at(t + DF, 1, 16'hFFFF, "R5 hold during float");
    expect_at(t + 1 + DF, 0, 16'h0, "R7 undriven while programming");
    gap(8);
    apply(1, 1, 1, 0, 5, 16'h1234);
    gap(8);
    apply(1, 0, 1, 0, 5, 16'h1234);
    expect_at(t + OEC, 0, 16'h0, "R3 not valid before oe delay");
    expect_at(t + 1 + OEC, 1, 16'h1234, "R8 verify reads programmed word");
    gap(8);

    // Second program pass: bits only clear
    apply(1, 1, 1, 0, 5, 16'hFF00);
    gap(8);
    apply(0, 1, 1, 0, 5, 16'hFF00);
    gap(4);
    apply(1, 1, 1, 0, 5, 16'hFF00);
    gap(8);
    apply(1, 0, 1, 0, 5, 16'hFF00);
    expect_at(t + 1 + OEC, 1, 16'h1200, "R12 AND programming");
    gap(8);

    // Program attempt with supply normal
    apply(1, 1, 1, 0, 5, 16'h0000);
    gap(8);
    apply(1, 1, 0, 0, 5, 16'h0000);
    gap(8);
    apply(0, 1, 0, 0, 5, 16'h0000);
    expect_at(t + 4, 0, 16'h0, "R4 oe high undriven");
    gap(8);
    apply(0, 0, 0, 0, 5, 16'h0000);
    expect_at(t + OEC, 0, 16'h0, "R3 oe delay");
    expect_at(t + 1 + OEC, 1, 16'h1200, "R10 no write with supply normal");
    gap(8);

    // Address change: hold then new word
    apply(0, 0, 0, 0, 6, 0);
    expect_at(t + ACC, 1, 16'h1200, "R6 hold old word");
    expect_at(t + 1 + ACC, 1, 16'hFFFF, "R2 new word after access");
    gap(8);

    // Output enable high, then standby
    apply(0, 1, 0, 0, 6, 0);
    expect_at(t + DF, 1, 16'hFFFF, "R5 float delay hold");
    expect_at(t + 1 + DF, 0, 16'h0, "R4 oe high floats");
    gap(8);
    apply(1, 0, 0, 0, 6, 0);
    expect_at(t + ACC + 4, 0, 16'h0, "R4 standby undriven");
    gap(ACC + 6);

    // Identification
    apply(0, 0, 0, 1, 0, 0);
    expect_at(t + ACC, 0, 16'h0, "R2 access delay on ce fall");
    expect_at(t + 1 + ACC, 1, 16'h001E, "R11 manufacturer word");
    gap(8);
    apply(0, 0, 0, 1, 1, 0);
    expect_at(t + ACC, 1, 16'h001E, "R6 hold id word");
    expect_at(t + 1 + ACC, 1, 16'h00F4, "R11 device word");
    gap(8);
    apply(0, 0, 0, 1, 10'h201, 0);
    expect_at(t + 1 + ACC, 1, 16'h00F4, "R11 bit9 level ignored");
    gap(8);
    apply(0, 0, 0, 1, 3, 0);
    expect_at(t + 1 + ACC, 1, 16'hFFFF, "R11 other bit set reads array");
    gap(8);

    // Inhibit must not write
    apply(1, 1, 0, 0, 6, 0);
    gap(8);
    apply(1, 1, 1, 0, 6, 0);
    gap(8);
    apply(1, 0, 1, 0, 6, 0);
    expect_at(t + 1 + OEC, 1, 16'hFFFF, "R9 inhibit leaves word");
    gap(8);

    wait (sb.size() == 0);
    gap(1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule